// File: doc/BRIEF.md
# RTC Periodic Counter Calibration Unit

This block divides the oscillator-rate clock enable of a real-time clock down to a one-second tick and trims the clock's long-term rate digitally. A two-stage divider (a prescaler of 2^PRE_W cycles feeding a block counter of 2^SUB_W blocks) produces the second. A 64-minute correction cycle then changes the length of chosen seconds. A signed five-bit code selects how many minutes of that cycle carry a corrected second. A positive code makes the clock run fast by dropping one prescaler block from the second. A negative code makes it run slow by stretching the first block of the second by half a block. With the default parameters the block counts 32,768 cycles per second, and one correction step is worth 256 or 128 oscillator cycles.

The tick drives a calendar core. The minute-position output shows where the block is in the 64-minute cycle. A free-running divider, separate from the corrected chain, gives a square wave for frequency test, 512 Hz at the default parameters. The block reads the calibration code only when the cycle wraps, so software may write the code at any time. A stop input halts and clears the divider. When stop is released, the next tick follows within one second.

The correction sequencer is a state machine that holds the kind of the current second. SM_PLAIN is an uncorrected second. SM_SHORT is a second one block short. SM_LONG is a second stretched by half a block. SM_HALT means the divider is stopped. Any state goes to SM_HALT while stop is high. SM_HALT leaves, on the first clock after stop falls, to the kind of second for the current second and minute. SM_PLAIN, SM_SHORT and SM_LONG change only at the end of a second. The next state is SM_SHORT or SM_LONG (chosen by the latched sign) if the next second opens a minute whose index is below twice the latched magnitude. Otherwise the next state is SM_PLAIN.

Top module: `rtc_cal_divider`

## Requirements
- R1: A second that is not corrected lasts exactly 2^(PRE_W+SUB_W) enabled oscillator cycles. With a magnitude of 0, every second is uncorrected.
- R2: When the latched sign is 1 (positive), the first second of each minute 0 to 2N-1 of the cycle lasts one block (2^PRE_W cycles) less, where N is the latched magnitude.
- R3: When the latched sign is 0 (negative), the first second of each minute 0 to 2N-1 lasts half a block (2^(PRE_W-1) cycles) more.
- R4: A full 64-minute cycle holds 64·SEC_PER_MIN·2^(PRE_W+SUB_W) cycles, minus 2N·2^PRE_W for a positive sign or plus N·2^PRE_W for a negative sign.
- R5: cal_mag and cal_pos are sampled only as minute 63 wraps to minute 0. The first cycle after reset is uncorrected whatever the inputs are, and a change in the middle of a cycle does not alter that cycle.
- R6: minute_pos starts at 0 and steps by one after every SEC_PER_MIN ticks, wrapping from 63 to 0. It does not change between ticks.
- R7: tick_1hz is a pulse one clock wide at the end of each second.
- R8: Only clocks with osc_en high advance the divider. A clock with osc_en low produces no tick and does not change minute_pos.
- R9: While ft_en is 1 and stop is 0, ft_out is a square wave with a period of 2^FT_W enabled cycles, whatever the calibration setting.
- R10: ft_out is 0 while ft_en is 0, and from the clock after stop rises.
- R11: While stop is high, no tick is given and minute_pos holds. After stop falls, the next tick comes no later than one clock plus the longest second.
- R12: After reset, tick_1hz, minute_pos and ft_out are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| stop | input | 1 | Halts and clears the divider while high |
| cal_mag | input | 5 | Calibration magnitude, 0 to 31 |
| cal_pos | input | 1 | Calibration sign: 1 speeds up, 0 slows down |
| ft_en | input | 1 | Enables the frequency-test output |
| tick_1hz | output | 1 | One-clock pulse at the end of each second |
| minute_pos | output | 6 | Minute index within the 64-minute cycle |
| ft_out | output | 1 | Frequency-test square wave |

## Verification
The hardest condition to reach from the ports is the moment the setting is latched. A setting takes effect only at a cycle wrap, and a wrong latch point shows up only as a different count across a whole cycle. The bench therefore scales the divider down and changes the code a few seconds into every cycle, with a new value for each cycle, sweeping every magnitude with both signs. It compares the length of each second against a model that applies the code only at the wrap. One whole cycle runs with osc_en pulsing every other clock, so that the bench can tell enabled cycles apart from clocks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int CAL_W = 5;   // calibration magnitude width
    localparam int MIN_W = 6;   // minute index in the 64-minute cycle

    typedef enum logic [1:0] {
        SM_PLAIN = 2'd0,
        SM_SHORT = 2'd1,
        SM_LONG  = 2'd2,
        SM_HALT  = 2'd3
    } sec_mode_e;
endpackage

// File: rtl/rtc_cal_prescaler.sv
// First divider stage: counts oscillator cycles into blocks; the first block
// of a stretched second lasts one and a half blocks.
module rtc_cal_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    input  logic stretch,
    output logic blk_done
);
    localparam int CW = PRE_W + 1;
    localparam logic [CW-1:0] LIM_NORM = CW'((1 << PRE_W) - 1);
    localparam logic [CW-1:0] LIM_LONG = CW'((1 << PRE_W) + (1 << (PRE_W - 1)) - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit    = stretch ? LIM_LONG : LIM_NORM;
    assign blk_done = adv && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= blk_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_cal_blkcnt.sv
// Second divider stage: counts blocks into a second; a shortened second
// ends one block early.
module rtc_cal_blkcnt #(
    parameter int SUB_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    input  logic skip,
    output logic sec_done,
    output logic first_blk
);
    localparam logic [SUB_W-1:0] LAST_NORM = SUB_W'((1 << SUB_W) - 1);
    localparam logic [SUB_W-1:0] LAST_SKIP = SUB_W'((1 << SUB_W) - 2);

    logic [SUB_W-1:0] blk_q;
    logic [SUB_W-1:0] last;

    assign last      = skip ? LAST_SKIP : LAST_NORM;
    assign sec_done  = adv && (blk_q == last);
    assign first_blk = (blk_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (clr) begin
            blk_q <= '0;
        end else if (adv) begin
            blk_q <= sec_done ? '0 : blk_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_cal_seq.sv
// Correction sequencer: second/minute position, per-cycle latch of the
// calibration code and the state machine naming the kind of each second.
module rtc_cal_seq
    import rtc_cal_pkg::*;
#(
    parameter int SEC_PER_MIN = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             sec_done,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    output logic             short_sec,
    output logic             long_sec,
    output logic             halted,
    output logic [MIN_W-1:0] minute
);
    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [MIN_W-1:0] MIN_LAST = '1;

    sec_mode_e state_q, state_d;

    logic [MIN_W-1:0] min_q;
    logic [CAL_W-1:0] mag_q;
    logic             pos_q;
    logic             s_last;   // current second is the last of its minute
    logic             s_first;  // current second is the first of its minute
    logic             wrap;
    logic [MIN_W-1:0] min_next;
    logic [CAL_W-1:0] eff_mag;
    logic             eff_pos;

    function automatic sec_mode_e pick_mode(input logic             first,
                                            input logic [MIN_W-1:0] m,
                                            input logic [CAL_W-1:0] mag,
                                            input logic             pos);
        if (first && (m < {mag, 1'b0})) begin
            return pos ? SM_SHORT : SM_LONG;
        end
        return SM_PLAIN;
    endfunction

    generate
        if (SEC_PER_MIN > 1) begin : g_sec_cnt
            localparam logic [SEC_W-1:0] S_LAST = SEC_W'(SEC_PER_MIN - 1);
            logic [SEC_W-1:0] sec_q;
            assign s_last  = (sec_q == S_LAST);
            assign s_first = (sec_q == '0);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sec_q <= '0;
                end else if (sec_done) begin
                    sec_q <= s_last ? '0 : sec_q + 1'b1;
                end
            end
        end else begin : g_sec_one
            assign s_last  = 1'b1;
            assign s_first = 1'b1;
        end
    endgenerate

    assign wrap     = s_last && (min_q == MIN_LAST);
    assign min_next = s_last ? min_q + 1'b1 : min_q;
    assign eff_mag  = wrap ? cal_mag : mag_q;
    assign eff_pos  = wrap ? cal_pos : pos_q;

    // position and latched code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q <= '0;
            mag_q <= '0;
            pos_q <= 1'b0;
        end else if (sec_done) begin
            min_q <= min_next;
            if (wrap) begin
                mag_q <= cal_mag;
                pos_q <= cal_pos;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = SM_HALT;
        end else begin
            unique case (state_q)
                SM_HALT:  state_d = pick_mode(s_first, min_q, mag_q, pos_q);
                SM_PLAIN,
                SM_SHORT,
                SM_LONG:  if (sec_done) state_d = pick_mode(s_last, min_next, eff_mag, eff_pos);
                default:  state_d = SM_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SM_PLAIN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        short_sec = 1'b0;
        long_sec  = 1'b0;
        halted    = 1'b0;
        unique case (state_q)
            SM_PLAIN: ;
            SM_SHORT: short_sec = 1'b1;
            SM_LONG:  long_sec  = 1'b1;
            SM_HALT:  halted    = 1'b1;
            default:  halted    = 1'b1;
        endcase
    end

    assign minute = min_q;
endmodule

// File: rtl/rtc_cal_ftgen.sv
// Free-running test divider, independent of the corrected chain.
module rtc_cal_ftgen #(
    parameter int FT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    input  logic ft_en,
    output logic ft_out
);
    logic [FT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ft_out = ft_en && cnt_q[FT_W-1];
endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider
    import rtc_cal_pkg::*;
#(
    parameter int PRE_W       = 8,
    parameter int SUB_W       = 7,
    parameter int SEC_PER_MIN = 60,
    parameter int FT_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             stop,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             ft_en,
    output logic             tick_1hz,
    output logic [MIN_W-1:0] minute_pos,
    output logic             ft_out
);
    logic run;
    logic adv;
    logic blk_done;
    logic sec_done;
    logic first_blk;
    logic short_sec;
    logic long_sec;
    logic halted;
    logic tick_q;

    assign run = !stop && !halted;
    assign adv = osc_en && run;

    rtc_cal_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .clr      (!run),
        .stretch  (long_sec && first_blk),
        .blk_done (blk_done)
    );

    rtc_cal_blkcnt #(.SUB_W(SUB_W)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (blk_done),
        .clr       (!run),
        .skip      (short_sec),
        .sec_done  (sec_done),
        .first_blk (first_blk)
    );

    rtc_cal_seq #(.SEC_PER_MIN(SEC_PER_MIN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop      (stop),
        .sec_done  (sec_done),
        .cal_mag   (cal_mag),
        .cal_pos   (cal_pos),
        .short_sec (short_sec),
        .long_sec  (long_sec),
        .halted    (halted),
        .minute    (minute_pos)
    );

    rtc_cal_ftgen #(.FT_W(FT_W)) u_ft (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (osc_en && !stop),
        .clr    (stop),
        .ft_en  (ft_en),
        .ft_out (ft_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= sec_done;
        end
    end

    assign tick_1hz = tick_q;
endmodule

// File: rtl/rtc_cal_divider_chk.sv
module rtc_cal_divider_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_en,
    input logic       stop,
    input logic       ft_en,
    input logic       tick_1hz,
    input logic [5:0] minute_pos,
    input logic       ft_out
);
    // R7: tick is one clock wide
    p_tick_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |=> !tick_1hz);

    // R6: minute index holds or steps by one (wrapping)
    p_minute_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (minute_pos == $past(minute_pos)) ||
                 (minute_pos == 6'($past(minute_pos) + 6'd1)));

    // R6: minute index only moves together with a tick
    p_minute_with_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz |-> $stable(minute_pos));

    // R8: an idle oscillator clock advances nothing
    p_osc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !tick_1hz && $stable(minute_pos));

    // R11: stop suppresses ticks and freezes the minute
    p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !tick_1hz && $stable(minute_pos));

    // R10: test output quiet when disabled or after stop
    p_ft_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ft_en |-> !ft_out);
    p_ft_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !ft_out);
endmodule

bind rtc_cal_divider rtc_cal_divider_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .stop       (stop),
    .ft_en      (ft_en),
    .tick_1hz   (tick_1hz),
    .minute_pos (minute_pos),
    .ft_out     (ft_out)
);

// File: tb/tb_rtc_cal_divider.sv
module tb_rtc_cal_divider;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W = 2;
    localparam int SUB_W = 2;
    localparam int SPM   = 2;
    localparam int FT_W  = 3;
    localparam int BLK   = 1 << PRE_W;
    localparam int CPS   = 1 << (PRE_W + SUB_W);
    localparam int SPC   = 64 * SPM;
    localparam int NCYC  = 70;
    localparam int ALT_CYC = 3;
    localparam int LAST_CYC = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en;
    logic       stop = 1'b0;
    logic [4:0] cal_mag = 5'd5;
    logic       cal_pos = 1'b1;
    logic       ft_en = 1'b0;
    logic       tick_1hz;
    logic [5:0] minute_pos;
    logic       ft_out;

    int tests = 0;
    int fails = 0;

    int set_mag [NCYC];
    int set_pos [NCYC];
    int cyc_total [NCYC];
    int cyc_clk [NCYC];
    int sec_idx = 0;
    bit chk_on = 1'b1;
    bit ft_chk = 1'b0;
    int err_plain = 0, err_short = 0, err_long = 0, err_min = 0, err_tick = 0, err_ft = 0;
    int n_plain = 0, n_short = 0, n_long = 0, n_ft = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_cal_divider #(
        .PRE_W(PRE_W), .SUB_W(SUB_W), .SEC_PER_MIN(SPM), .FT_W(FT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
        .cal_mag(cal_mag), .cal_pos(cal_pos), .ft_en(ft_en),
        .tick_1hz(tick_1hz), .minute_pos(minute_pos), .ft_out(ft_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected length of second j (0-based since reset), in enabled cycles
    function automatic int exp_len(input int j, output int kind);
        int c, w, mn;
        c  = j / SPC;
        w  = j % SPC;
        mn = w / SPM;
        if ((w % SPM) == 0 && mn < 2 * set_mag[c]) begin
            kind = set_pos[c] ? 1 : 2;
            return set_pos[c] ? CPS - BLK : CPS + BLK / 2;
        end
        kind = 0;
        return CPS;
    endfunction

    // monitor: owns osc_en, measures seconds, cycles and test-output periods
    initial begin
        int acc, clk_cyc, cyc_sum, ft_acc, kind, e, c;
        bit tick_prev, ft_prev, ft_armed, phase;
        logic [5:0] min_prev;
        acc = 0; clk_cyc = 0; cyc_sum = 0; ft_acc = 0;
        tick_prev = 0; ft_prev = 0; ft_armed = 0; phase = 0; min_prev = '0;
        osc_en = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                acc = 0; clk_cyc = 0; cyc_sum = 0;
            end else begin
                acc += int'(osc_en);
                clk_cyc++;
                if (tick_1hz) begin
                    if (tick_prev) err_tick++;
                    if (chk_on) begin
                        e = exp_len(sec_idx, kind);
                        case (kind)
                            0: begin n_plain++; if (acc != e) err_plain++; end
                            1: begin n_short++; if (acc != e) err_short++; end
                            default: begin n_long++; if (acc != e) err_long++; end
                        endcase
                    end
                    cyc_sum += acc;
                    sec_idx++;
                    if (chk_on && minute_pos != 6'((sec_idx / SPM) % 64)) err_min++;
                    if (sec_idx % SPC == 0) begin
                        c = sec_idx / SPC - 1;
                        if (c < NCYC) begin
                            cyc_total[c] = cyc_sum;
                            cyc_clk[c]   = clk_cyc;
                        end
                        cyc_sum = 0;
                        clk_cyc = 0;
                    end
                    acc = 0;
                end else if (chk_on && minute_pos != min_prev) begin
                    err_min++;
                end
                if (ft_chk) begin
                    ft_acc += int'(osc_en);
                    if (ft_out && !ft_prev) begin
                        if (ft_armed) begin
                            n_ft++;
                            if (ft_acc != (1 << FT_W)) err_ft++;
                        end
                        ft_armed = 1;
                        ft_acc = 0;
                    end
                end else begin
                    ft_armed = 0;
                    ft_acc = 0;
                end
            end
            tick_prev = tick_1hz;
            ft_prev   = ft_out;
            min_prev  = minute_pos;
            if (rst_n && (sec_idx / SPC) == ALT_CYC) begin
                phase  = !phase;
                osc_en = phase;
            end else begin
                osc_en = 1'b1;
            end
        end
    end

    task automatic t_reset;
        int bad;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(tick_1hz == 1'b0, "R12 tick after reset", tick_1hz, 0);
        check(minute_pos == 6'd0, "R12 minute after reset", minute_pos, 0);
        check(ft_out == 1'b0, "R12 ft_out after reset", ft_out, 0);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (ft_out) bad++;
        end
        check(bad == 0, "R10 ft_out with ft_en low", bad, 0);
        ft_en  = 1'b1;
        ft_chk = 1'b1;
    endtask

    task automatic t_sweep;
        int m, p, exp;
        for (int c = 2; c <= LAST_CYC; c++) begin
            if (c <= 32) begin m = c - 1; p = 1; end
            else begin m = c - 33; p = 0; end
            wait (sec_idx >= (c - 1) * SPC + 3);
            @(negedge clk);
            cal_mag = 5'(m);
            cal_pos = p[0];
            set_mag[c] = m;
            set_pos[c] = p;
        end
        wait (sec_idx >= (LAST_CYC + 1) * SPC);
        @(negedge clk);
        check(cyc_total[0] == 64 * SPM * CPS, "R5 first cycle uncorrected", cyc_total[0], 64 * SPM * CPS);
        exp = 64 * SPM * CPS - 2 * 5 * BLK;
        check(cyc_total[1] == exp, "R5 code applied at wrap", cyc_total[1], exp);
        for (int c = 2; c <= LAST_CYC; c++) begin
            if (set_pos[c] != 0) exp = 64 * SPM * CPS - 2 * set_mag[c] * BLK;
            else                 exp = 64 * SPM * CPS + set_mag[c] * BLK;
            check(cyc_total[c] == exp, "R4 cycle total", cyc_total[c], exp);
        end
        check(err_plain == 0 && n_plain > 0, "R1 plain second length", err_plain, 0);
        check(err_short == 0 && n_short > 0, "R2 shortened second length", err_short, 0);
        check(err_long == 0 && n_long > 0, "R3 stretched second length", err_long, 0);
        check(err_min == 0, "R6 minute position", err_min, 0);
        check(err_tick == 0, "R7 tick width", err_tick, 0);
        check(err_ft == 0 && n_ft > 100, "R9 test period", err_ft, 0);
        check(cyc_clk[ALT_CYC] >= 2 * cyc_total[ALT_CYC] - 1 && cyc_clk[ALT_CYC] <= 2 * cyc_total[ALT_CYC] + 1,
              "R8 half-rate enable doubles clocks", cyc_clk[ALT_CYC], 2 * cyc_total[ALT_CYC]);
        exp = 64 * SPM * CPS - 2 * set_mag[ALT_CYC] * BLK;
        check(cyc_total[ALT_CYC] == exp, "R8 half-rate enable cycle total", cyc_total[ALT_CYC], exp);
    endtask

    task automatic t_stop;
        int bad_t, bad_m, bad_f, n;
        logic [5:0] m0;
        @(negedge clk);
        chk_on = 1'b0;
        ft_chk = 1'b0;
        stop   = 1'b1;
        @(negedge clk);
        m0 = minute_pos;
        bad_t = 0; bad_m = 0; bad_f = 0;
        repeat (200) begin
            @(negedge clk);
            if (tick_1hz) bad_t++;
            if (minute_pos != m0) bad_m++;
            if (ft_out) bad_f++;
        end
        check(bad_t == 0, "R11 no tick while stopped", bad_t, 0);
        check(bad_m == 0, "R11 minute frozen while stopped", bad_m, 0);
        check(bad_f == 0, "R10 ft_out low while stopped", bad_f, 0);
        stop = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_1hz && n < 100);
        check(n >= CPS - BLK + 1 && n <= CPS + BLK / 2 + 1, "R11 tick within one second of restart", n, CPS + 1);
        ft_en = 1'b0;
        bad_f = 0;
        repeat (50) begin
            @(negedge clk);
            if (ft_out) bad_f++;
        end
        check(bad_f == 0, "R10 ft_out low after disable", bad_f, 0);
    endtask

    initial begin
        for (int i = 0; i < NCYC; i++) begin
            set_mag[i] = 0; set_pos[i] = 0; cyc_total[i] = 0; cyc_clk[i] = 0;
        end
        set_mag[1] = 5;
        set_pos[1] = 1;
        t_reset();
        t_sweep();
        t_stop();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", sec_idx, (LAST_CYC + 1) * SPC);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule